// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the feedback divider value M, the post-divider select N and a three-bit test selector T for a frequency synthesizer. There are two ways to load them. A parallel port presents M and N directly. A serial port shifts a configuration word in bit by bit and then commits it in one step. The downstream PLL, its dividers and its output drivers read the held values and are not part of this block.

The parallel hold line selects which port has control. While it is low, the active M and N follow the parallel pins and T is forced to zero. Its rising edge freezes the values present on the pins at that moment. While it is high, the serial port may shift a 14-bit word: T first, then N, then M, each field most significant bit first. A falling edge on the commit line then copies the word into the active registers, but only once fourteen bits have been shifted since reset.

All asynchronous control lines are brought into the system clock through a synchronizer of SYNC_STAGES flops, and edges are found by comparing with a registered copy. Each input therefore takes effect a fixed number of clock cycles after it changes.

Top module: `divcfg_loader`

## Requirements
- R1: While reset is asserted, act_m, act_n, act_t and ser_dout are all zero, and the serial bit count is cleared.
- R2: While par_hold is low, act_m and act_n follow par_m and par_n, within SYNC_STAGES+1 clock cycles of a change.
- R3: A rising edge on par_hold captures par_m and par_n. While par_hold stays high, later changes on par_m and par_n have no effect on act_m or act_n.
- R4: act_t reads 000 whenever par_hold is low. The parallel port has no path to act_t.
- R5: Each rising edge of ser_clk while par_hold is high shifts ser_din into the LSB of a 14-bit shift register. ser_dout shows the register's MSB, which is the bit shifted in 13 shifts earlier, or 0 if fewer than 14 bits have been shifted since reset.
- R6: The serial word maps onto the active values by bit position. Bits 13..11 go to T, bits 10..9 go to N and bits 8..0 go to M. The first bit shifted lands in bit 13, so each field arrives MSB first.
- R7: A falling edge of ser_commit while par_hold is high, after at least 14 bits have been shifted since reset, loads the shift register into act_t, act_n and act_m. Repeating the commit without shifting more bits reloads the same word.
- R8: A commit before 14 bits have been shifted since reset leaves act_m, act_n and act_t unchanged.
- R9: While par_hold is low, ser_clk edges shift nothing and ser_commit edges commit nothing. The shift register and the bit count are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_hold | input | 1 | Parallel control: low makes the port transparent, the rising edge captures, high hands control to the serial port |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N select |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_din | input | 1 | Serial data, taken on the rising edge of ser_clk |
| ser_commit | input | 1 | Serial commit strobe, acts on its falling edge |
| act_m | output | 9 | Active M value |
| act_n | output | 2 | Active N select |
| act_t | output | 3 | Active test selector |
| ser_dout | output | 1 | MSB of the shift register |

## Verification
A shift register or bit count that has drifted does not show on the active outputs until the next commit. At that point the T, N and M fields come out rotated, or an early commit is accepted when it should be refused. ser_dout exposes the MSB after every shift, so a misplaced or missed shift appears there within one synchronized serial clock period. A fault in the hold-line arbitration shows on act_t, or as act_m that fails to follow or fails to freeze, within SYNC_STAGES+1 cycles.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int M_W  = 9;
    localparam int N_W  = 2;
    localparam int T_W  = 3;
    localparam int SR_W = T_W + N_W + M_W;
    localparam int CNT_W = $clog2(SR_W + 1);

    // Active configuration, laid out in serial bit order (T at the MSB end)
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    // Raw input bundle carried through the synchronizer
    typedef struct packed {
        logic           hold;
        logic           sclk;
        logic           sdin;
        logic           commit;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } in_bus_t;

    localparam int IN_W = $bits(in_bus_t);

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign pipe_d[g] = d;
        end else begin : g_rest
            assign pipe_d[g] = pipe_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cfgld_edge.sv
module cfgld_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
        fall   = ~sig & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         full,
    output logic [$clog2(W+1)-1:0] fill
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[W-2:0], din};
            if (st_q.cnt != CW'(W)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;
    assign full = (st_q.cnt == CW'(W));
    assign fill = st_q.cnt;

endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import cfgld_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_hold,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_din,
    input  logic           ser_commit,
    output logic [M_W-1:0] act_m,
    output logic [N_W-1:0] act_n,
    output logic [T_W-1:0] act_t,
    output logic           ser_dout
);

    localparam int EDGE_W = 3;
    localparam int E_HOLD = 2;
    localparam int E_SCLK = 1;
    localparam int E_CMT  = 0;

    in_bus_t raw_in, syn_in;
    logic [EDGE_W-1:0] edge_sig, edge_rise, edge_fall;

    logic hold_s, hold_rise, sclk_rise, commit_fall;
    logic shift_en, commit_ok, sr_full;
    logic [SR_W-1:0]  sr_word;
    logic [CNT_W-1:0] sr_fill;
    logic [M_W-1:0]   m_s;
    logic [N_W-1:0]   n_s;

    cfg_t cfg_d, cfg_q;

    assign raw_in = '{hold: par_hold, sclk: ser_clk, sdin: ser_din,
                      commit: ser_commit, n: par_n, m: par_m};

    cfgld_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign edge_sig = {syn_in.hold, syn_in.sclk, syn_in.commit};

    cfgld_edge #(.W(EDGE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (edge_sig),
        .rise  (edge_rise),
        .fall  (edge_fall)
    );

    assign hold_s      = syn_in.hold;
    assign m_s         = syn_in.m;
    assign n_s         = syn_in.n;
    assign hold_rise   = edge_rise[E_HOLD];
    assign sclk_rise   = edge_rise[E_SCLK];
    assign commit_fall = edge_fall[E_CMT];
    assign shift_en    = hold_s & sclk_rise;
    assign commit_ok   = hold_s & ~hold_rise & commit_fall & sr_full;

    cfgld_shifter #(.W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (syn_in.sdin),
        .word     (sr_word),
        .full     (sr_full),
        .fill     (sr_fill)
    );

    // Parallel port owns the registers while hold is low and on its rising
    // edge; the serial commit is honoured only while hold stays high.
    always_comb begin
        cfg_d = cfg_q;
        if (!hold_s || hold_rise) begin
            cfg_d.t = '0;
            cfg_d.n = n_s;
            cfg_d.m = m_s;
        end else if (commit_ok) begin
            cfg_d = cfg_t'(sr_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign act_m    = cfg_q.m;
    assign act_n    = cfg_q.n;
    assign act_t    = cfg_q.t;
    assign ser_dout = sr_word[SR_W-1];

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker
    import cfgld_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hold_s,
    input logic             hold_rise,
    input logic             commit_fall,
    input logic             sr_full,
    input logic [CNT_W-1:0] sr_fill,
    input logic [M_W-1:0]   m_s,
    input logic [N_W-1:0]   n_s,
    input logic [M_W-1:0]   act_m,
    input logic [N_W-1:0]   act_n,
    input logic [T_W-1:0]   act_t,
    input logic             ser_dout
);

    a_r4_test_zero_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> act_t == '0);

    a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> (act_m == $past(m_s) && act_n == $past(n_s)));

    a_r3_frozen_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_s && !hold_rise && !commit_fall) |=>
            ($stable(act_m) && $stable(act_n) && $stable(act_t)));

    a_r8_early_commit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_s && !hold_rise && !sr_full) |=>
            ($stable(act_m) && $stable(act_n) && $stable(act_t)));

    a_r9_no_shift_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> ($stable(ser_dout) && $stable(sr_fill)));

    a_r5_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        sr_fill <= CNT_W'(SR_W));

endmodule

bind divcfg_loader cfgld_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_s      (hold_s),
    .hold_rise   (hold_rise),
    .commit_fall (commit_fall),
    .sr_full     (sr_full),
    .sr_fill     (sr_fill),
    .m_s         (m_s),
    .n_s         (n_s),
    .act_m       (act_m),
    .act_n       (act_n),
    .act_t       (act_t),
    .ser_dout    (ser_dout)
);

// File: tb/divcfg_loader_bench.sv
module divcfg_loader_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_hold = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_commit = 1'b0;
    logic [8:0] act_m;
    logic [1:0] act_n;
    logic [2:0] act_t;
    logic       ser_dout;

    always #10 clk = ~clk;

    divcfg_loader u_divcfg_loader (
        .clk(clk), .rst_n(rst_n), .par_hold(par_hold), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_commit(ser_commit), .act_m(act_m), .act_n(act_n),
        .act_t(act_t), .ser_dout(ser_dout)
    );

    typedef struct {
        logic [8:0] m;
        logic [1:0] n;
        logic [2:0] t;
        logic       dout;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // requirement-level model
    logic [8:0]  e_m = '0;
    logic [1:0]  e_n = '0;
    logic [2:0]  e_t = '0;
    logic [13:0] e_sr = '0;
    int          e_cnt = 0;

    always @(chk_ev) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (act_m !== e.m || act_n !== e.n || act_t !== e.t || ser_dout !== e.dout) begin
                n_fail++;
                $display("FAIL %s: m/n/t/dout actual %h/%h/%h/%b expected %h/%h/%h/%b",
                         e.tag, act_m, act_n, act_t, ser_dout, e.m, e.n, e.t, e.dout);
            end
        end
    end

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag);
        exp_t e;
        e.m = e_m; e.n = e_n; e.t = e_t; e.dout = e_sr[13]; e.tag = tag;
        exp_q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    task automatic set_par(input logic [8:0] m, input logic [1:0] n, input logic hold);
        if (!hold || !par_hold) begin
            e_m = m; e_n = n; e_t = 3'b000;
        end
        par_m = m; par_n = n; par_hold = hold;
        settle();
    endtask

    task automatic shift_bit(input logic b);
        ser_din = b;
        settle();
        ser_clk = 1'b1;
        settle();
        ser_clk = 1'b0;
        settle();
        if (par_hold) begin
            e_sr = {e_sr[12:0], b};
            if (e_cnt < 14) e_cnt++;
        end
    endtask

    task automatic shift_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic commit();
        ser_commit = 1'b1;
        settle();
        ser_commit = 1'b0;
        settle();
        if (par_hold && e_cnt == 14) begin
            e_t = e_sr[13:11]; e_n = e_sr[10:9]; e_m = e_sr[8:0];
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        settle();

        set_par(9'h1A5, 2'd2, 1'b0);
        check("R2 R4 transparent with test zero");
        set_par(9'h033, 2'd1, 1'b0);
        check("R2 follows new parallel value");

        set_par(9'h0F0, 2'd3, 1'b1);
        check("R3 rising hold captures");
        set_par(9'h111, 2'd0, 1'b1);
        check("R3 parallel change ignored while high");

        for (int i = 0; i < 13; i++) shift_bit(1'b1);
        check("R5 msb still zero after 13 shifts");
        commit();
        check("R8 early commit ignored");

        set_par(9'h155, 2'd1, 1'b0);
        check("R4 test cleared when hold low");
        shift_bit(1'b0);
        check("R9 shift ignored while hold low");
        commit();
        check("R9 commit ignored while hold low");
        set_par(9'h155, 2'd1, 1'b1);

        shift_word({3'b101, 2'b10, 9'h12D});
        check("R5 msb shows first bit of word");
        commit();
        check("R6 R7 fields mapped after commit");

        set_par(9'h0AA, 2'd0, 1'b1);
        check("R3 parallel ignored after serial load");

        shift_word({3'b011, 2'b01, 9'h0C6});
        commit();
        check("R6 second word committed");
        commit();
        check("R7 repeat commit reloads same word");

        set_par(9'h0AA, 2'd0, 1'b0);
        check("R4 hold low returns to parallel with test zero");

        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule